// File: doc/BRIEF.md
# UART Receiver with Idle Timeout

This block receives asynchronous serial data, eight data bits and one stop bit, least significant bit first. A two-stage synchronizer brings the line into the clock domain. A frame state machine then times each bit with a programmable divisor, given as system clocks per bit. Received bytes go into a 32-entry first-in first-out store. The host reads that store through a show-ahead port and can see its fill level at all times.

An idle timer measures quiet time on the line in whole bit periods. It is armed by a successfully received byte. When the quiet time reaches an 8-bit threshold, it raises a timeout interrupt once for that gap. This lets the host collect the tail of a short message without polling. Framing errors and overruns raise their own flags. All three flags are sticky and each has its own write-one-to-clear input.

Frame state machine: states `S_IDLE`, `S_START`, `S_DATA` and `S_STOP`. Transitions:
- *detect*: `S_IDLE` to `S_START` when the line is low.
- *reject*: `S_START` to `S_IDLE` when the line is high at half a bit.
- *confirm*: `S_START` to `S_DATA` when the line is low at half a bit.
- *last bit*: `S_DATA` to `S_STOP` after the eighth sample.
- *finish*: `S_STOP` to `S_IDLE` at the stop-bit sample.

Top module: `uart_rx_idle`

## Requirements
- R1: After reset, `level_o` is 0 and all three interrupt flags are 0.
- R2: A frame consists of one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts `div_i` clocks, and each bit is sampled near its middle. Every received byte is stored in arrival order.
- R3: The store holds 32 bytes. `level_o` gives the number held. `rd_data_o` shows the oldest byte. A `rd_en_i` pulse removes that byte. A `rd_en_i` pulse while the store is empty changes nothing.
- R4: A low pulse on the line that ends before the half-bit check is ignored. It stores nothing and sets no flag.
- R5: If the stop-bit sample is low, the byte is discarded and `irq_frame_o` is set.
- R6: If a byte completes while the store holds 32 bytes, the byte is dropped and `irq_overrun_o` is set. The stored contents and `level_o` stay unchanged.
- R7: After at least one byte has been received, `irq_timeout_o` is set once the line has been quiet for `timeout_i` bit periods. Before any byte has been received, the timeout never fires.
- R8: The timeout fires at most once per quiet gap. It fires again only after a new byte has been received.
- R9: Each flag stays set until its clear input is pulsed high. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| div_i | input | 16 | Clocks per bit, at least 4 |
| timeout_i | input | 8 | Quiet-time threshold in bit periods, at least 1 |
| rd_en_i | input | 1 | Remove the oldest stored byte |
| rd_data_o | output | 8 | Oldest stored byte |
| level_o | output | 6 | Number of stored bytes |
| irq_timeout_o | output | 1 | Sticky quiet-line interrupt |
| irq_frame_o | output | 1 | Sticky framing-error interrupt |
| irq_overrun_o | output | 1 | Sticky overrun interrupt |
| clr_timeout_i | input | 1 | Write-one-to-clear for `irq_timeout_o` |
| clr_frame_i | input | 1 | Write-one-to-clear for `irq_frame_o` |
| clr_overrun_i | input | 1 | Write-one-to-clear for `irq_overrun_o` |

## Verification
The assertions assume that `div_i` and `timeout_i` stay constant while a frame or a quiet gap is in progress. They also assume that `rd_en_i` is a single-cycle request. The stimulus sets both configuration values once, during reset, and never changes them. It pulses `rd_en_i` for exactly one cycle at a time, on the falling clock edge. Serial frames are driven on falling edges at an 8-clock bit period, so every line transition is clean.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_t;
endpackage

// File: rtl/rx_frame_fsm.sv
`timescale 1ns/1ps
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              byte_ok_o,
    output logic              frame_bad_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              busy_o
);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_t         state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [DIV_W-1:0]  half;
    logic              period_end;

    assign half       = div_i >> 1;
    assign period_end = (cnt_q == div_i - 1'b1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        bit_d   = bit_q;
        sh_d    = sh_q;
        unique case (state_q)
            S_IDLE: begin
                cnt_d = '0;
                if (!line_i) state_d = S_START;          // detect
            end
            S_START: begin
                if (cnt_q == half) begin
                    cnt_d   = '0;
                    bit_d   = '0;
                    state_d = line_i ? S_IDLE : S_DATA;  // reject / confirm
                end
            end
            S_DATA: begin
                if (period_end) begin
                    cnt_d = '0;
                    sh_d  = {line_i, sh_q[DATA_W-1:1]};
                    if (bit_q == BIT_W'(DATA_W - 1)) state_d = S_STOP; // last bit
                    else bit_d = bit_q + 1'b1;
                end
            end
            S_STOP: begin
                if (period_end) state_d = S_IDLE;        // finish
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        byte_ok_o   = (state_q == S_STOP) && period_end && line_i;
        frame_bad_o = (state_q == S_STOP) && period_end && !line_i;
        byte_o      = sh_q;
        busy_o      = (state_q != S_IDLE);
    end

    // R2: bit timer never runs past one bit period while shifting data
    a_r2_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA) |-> (cnt_q < div_i));
endmodule

// File: rtl/rx_fifo.sv
`timescale 1ns/1ps
module rx_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic                         rd_en_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [LW-1:0]     cnt_q;
    logic              do_wr, do_rd;

    assign full_o    = (cnt_q == LW'(DEPTH));
    assign do_wr     = wr_en_i && !full_o;
    assign do_rd     = rd_en_i && (cnt_q != '0);
    assign rd_data_o = mem[rp_q];
    assign level_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + LW'(do_wr) - LW'(do_rd);
        end
    end

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(DEPTH));
    // R6: the parent never offers a byte to a full store
    a_r6_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !full_o);
    // R3: a read of an empty store leaves the level at zero
    a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && cnt_q == '0 && !wr_en_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
module rx_idle_timer #(
    parameter int DIV_W = 16,
    parameter int TO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_done_i,
    input  logic             busy_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [TO_W-1:0]  limit_i,
    output logic             fire_o
);
    logic             armed_q;
    logic [DIV_W-1:0] cyc_q;
    logic [TO_W-1:0]  per_q;

    assign fire_o = armed_q && !busy_i && !byte_done_i && (per_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cyc_q   <= '0;
            per_q   <= '0;
        end else if (byte_done_i) begin
            armed_q <= 1'b1;
            cyc_q   <= '0;
            per_q   <= '0;
        end else if (busy_i) begin
            cyc_q   <= '0;
            per_q   <= '0;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end else if (armed_q) begin
            if (cyc_q == div_i - 1'b1) begin
                cyc_q <= '0;
                per_q <= per_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R7: nothing fires before a byte has armed the timer
    a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> armed_q);
endmodule

// File: rtl/uart_rx_idle.sv
`timescale 1ns/1ps
module uart_rx_idle #(
    parameter int DIV_W  = 16,
    parameter int TO_W   = 8,
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_i,
    input  logic [DIV_W-1:0]           div_i,
    input  logic [TO_W-1:0]            timeout_i,
    input  logic                       rd_en_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       irq_timeout_o,
    output logic                       irq_frame_o,
    output logic                       irq_overrun_o,
    input  logic                       clr_timeout_i,
    input  logic                       clr_frame_i,
    input  logic                       clr_overrun_i
);
    logic [1:0]        sync_q;
    logic              line_s;
    logic              byte_ok, frame_bad, busy, full, fire;
    logic              push, drop;
    logic [DATA_W-1:0] rx_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end
    assign line_s = sync_q[1];

    rx_frame_fsm #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_i(line_s), .div_i(div_i),
        .byte_ok_o(byte_ok), .frame_bad_o(frame_bad),
        .byte_o(rx_byte), .busy_o(busy)
    );

    assign push = byte_ok && !full;
    assign drop = byte_ok && full;

    rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en_i(push), .wr_data_i(rx_byte),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .level_o(level_o),
        .full_o(full)
    );

    rx_idle_timer #(.DIV_W(DIV_W), .TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .byte_done_i(byte_ok), .busy_i(busy),
        .div_i(div_i), .limit_i(timeout_i), .fire_o(fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_timeout_o <= 1'b0;
            irq_frame_o   <= 1'b0;
            irq_overrun_o <= 1'b0;
        end else begin
            irq_timeout_o <= (irq_timeout_o && !clr_timeout_i) || fire;
            irq_frame_o   <= (irq_frame_o   && !clr_frame_i)   || frame_bad;
            irq_overrun_o <= (irq_overrun_o && !clr_overrun_i) || drop;
        end
    end

    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_timeout_o && !clr_timeout_i) |=> irq_timeout_o);
    a_r9_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_frame_o && !clr_frame_i) |=> irq_frame_o);
    // R6: an overrun leaves the store level untouched
    a_r6_overrun_level: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !rd_en_i) |=> (level_o == $past(level_o)));
endmodule

// File: tb/uart_rx_idle_test.sv
`timescale 1ns/1ps
module uart_rx_idle_test;
    localparam int DIV = 8;
    localparam int TO  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       rd_en = 1'b0;
    logic       clr_to = 1'b0, clr_fr = 1'b0, clr_ov = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] level;
    logic       irq_to, irq_fr, irq_ov;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_rx_idle uut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .div_i(16'(DIV)),
        .timeout_i(8'(TO)), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .level_o(level), .irq_timeout_o(irq_to), .irq_frame_o(irq_fr),
        .irq_overrun_o(irq_ov), .clr_timeout_i(clr_to),
        .clr_frame_i(clr_fr), .clr_overrun_i(clr_ov)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_level);
        @(negedge clk);
        rx = 1'b0;
        idle(DIV);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            idle(DIV);
        end
        rx = stop_level;
        idle(DIV);
        rx = 1'b1;
        idle(4);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_all();
        clr_to = 1'b1; clr_fr = 1'b1; clr_ov = 1'b1;
        @(negedge clk);
        clr_to = 1'b0; clr_fr = 1'b0; clr_ov = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        chk("R1 level", level, 0);
        chk("R1 timeout flag", irq_to, 0);
        chk("R1 frame flag", irq_fr, 0);
        chk("R1 overrun flag", irq_ov, 0);

        idle(TO * DIV * 6);
        chk("R7 no fire before first byte", irq_to, 0);

        rx = 1'b0;
        idle(2);
        rx = 1'b1;
        idle(DIV * 12);
        chk("R4 glitch stores nothing", level, 0);
        chk("R4 glitch sets no frame flag", irq_fr, 0);

        for (int batch = 0; batch < 8; batch++) begin
            for (int i = 0; i < 32; i++) send(8'(batch * 32 + i), 1'b1);
            chk("R3 level full", level, 32);
            if (batch == 0) begin
                send(8'hA5, 1'b1);
                chk("R6 overrun flag", irq_ov, 1);
                chk("R6 level unchanged", level, 32);
                chk("R6 head unchanged", rd_data, 0);
            end
            for (int i = 0; i < 32; i++) begin
                chk("R2 byte value", rd_data, batch * 32 + i);
                pop();
                chk("R3 level after read", level, 31 - i);
            end
            pop();
            chk("R3 empty read ignored", level, 0);
        end

        idle(TO * DIV * 3);
        clear_all();
        chk("R9 clear overrun", irq_ov, 0);
        chk("R9 clear timeout", irq_to, 0);

        send(8'h3C, 1'b0);
        idle(DIV * 3);
        chk("R5 frame flag", irq_fr, 1);
        chk("R5 byte discarded", level, 0);
        idle(TO * DIV * 6);
        chk("R7 frame error does not arm", irq_to, 0);
        chk("R9 frame flag sticky", irq_fr, 1);
        clear_all();
        chk("R9 clear frame", irq_fr, 0);

        send(8'h96, 1'b1);
        idle(6);
        chk("R7 not yet fired", irq_to, 0);
        idle(TO * DIV + 8);
        chk("R7 timeout fired", irq_to, 1);
        chk("R2 byte before timeout", rd_data, 8'h96);
        clear_all();
        chk("R9 clear timeout after fire", irq_to, 0);
        idle(TO * DIV * 8);
        chk("R8 single fire per gap", irq_to, 0);
        pop();

        send(8'h5A, 1'b1);
        idle(TO * DIV + 14);
        chk("R8 rearmed by new byte", irq_to, 1);
        chk("R2 last byte", rd_data, 8'h5A);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule